// File: doc/BRIEF.md
# Boundary Scan Pin Cell Chain

This block is the boundary-scan data register that sits between a device's core logic and its pads. It is built from per-pin cells. Each bidirectional pin carries three shift stages, for output data, output enable and the sampled pad input. The data and enable stages each feed an update register. Each input-only pin carries a single shift stage. All stages are joined into one serial chain. A test access controller outside the block drives it through four strobes: a data-register clock enable, a shift select, an update strobe and an external-test mode bit. A high-Z control and an active-low test output enable also act on the pins.

In normal operation every pad is driven by the core. Its enable is picked per pin from four shared enable terms, two global enable pins or the pin's own enable term. In external-test mode the pads are driven from the update registers instead. The test output enable and the high-Z control override both sources and turn every driver off. Serial data leaves the chain on the falling edge of the test clock.

Top module: `bsc_chain`

## Requirements
- R1: After an asynchronous reset all shift stages, update registers and scan_out_o are 0, so with extest_i high every pad_oe_o bit is 0 and every pad_out_o bit is 0.
- R2: On a rising test clock edge with clock_dr_i and shift_dr_i both high, each stage takes the value of the stage before it. The order from scan_in_i is as follows: for bidirectional pins 0 to NUM_BIDIR-1 in ascending order, the data stage, then the enable stage, then the pad-input stage; after those, input-only pins 0 to NUM_INPUT-1 in ascending order. The last input-only stage drives scan_out_o.
- R3: scan_out_o changes only on the falling edge of the test clock. A rising edge that shifts the chain leaves it unchanged until the next falling edge.
- R4: On a rising edge with clock_dr_i high and shift_dr_i low, each bidirectional pin's stages load func_out_i, the resolved functional enable and pad_in_i. Each input-only stage loads in_pin_i.
- R5: On a rising edge with update_dr_i high, the data and enable stages of each bidirectional pin are copied into its update registers. Shifting with update_dr_i low does not change pad_out_o or pad_oe_o.
- R6: With extest_i high, pad_out_o and the pre-override enable come from the update registers. With extest_i low they come from func_out_i and the resolved functional enable.
- R7: The functional enable of pin p is chosen by the 3-bit field oe_sel_i[3p+2:3p]. Codes 0 to 3 select gpt_oe_i[code], codes 4 and 5 select goe_pin_i[code-4], code 6 selects pt_oe_i[p], and code 7 gives a constant 0.
- R8: While test_oe_ni is low, every pad_oe_o bit is 0, whatever the mode and the enable sources.
- R9: While highz_i is high, every pad_oe_o bit is 0, whatever the mode and the enable sources.
- R10: With clock_dr_i low the shift stages hold their values, whatever shift_dr_i and scan_in_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clock_dr_i | input | 1 | Data-register clock enable (capture or shift) |
| shift_dr_i | input | 1 | Shift select; low means capture |
| update_dr_i | input | 1 | Update strobe |
| extest_i | input | 1 | External-test mode: pads driven from update registers |
| highz_i | input | 1 | Forces all pad drivers off |
| test_oe_ni | input | 1 | Active-low test output enable; low turns all drivers off |
| scan_in_i | input | 1 | Serial data into the chain |
| scan_out_o | output | 1 | Serial data out, changes on falling edge |
| func_out_i | input | NUM_BIDIR | Core output data per bidirectional pin |
| oe_sel_i | input | 3*NUM_BIDIR | Enable source select per pin |
| gpt_oe_i | input | 4 | Shared enable terms |
| goe_pin_i | input | 2 | Global enable pins |
| pt_oe_i | input | NUM_BIDIR | Per-pin enable term |
| pad_in_i | input | NUM_BIDIR | Pad input value per bidirectional pin |
| in_pin_i | input | NUM_INPUT | Input-only pin values |
| pad_out_o | output | NUM_BIDIR | Pad output data |
| pad_oe_o | output | NUM_BIDIR | Pad driver enable |

## Verification
The hardest situation to reach is a check of the full cell order together with the falling-edge timing of scan_out_o. Every stage must hold a value that can be told apart from its neighbours. The stimulus therefore captures a mix of core data, enables resolved from several different sources and pad inputs. It then holds the chain with clock_dr_i low while scan_in_i toggles, and shifts the whole length out. After the first shift edge, the bench samples scan_out_o once before the falling edge, and the two last stages are set up to differ at that point. The external-test path is reached by shifting a pattern in while watching that the pads stay put. The bench then pulses update and lays each override on top of the update-driven enables.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_GPT  = 4;
  localparam int unsigned NUM_GPIN = 2;
  localparam int unsigned CELLS_PER_BIDIR = 3;

  typedef enum logic [SEL_W-1:0] {
    OE_GPT0 = 3'd0, OE_GPT1 = 3'd1, OE_GPT2 = 3'd2, OE_GPT3 = 3'd3,
    OE_GPIN0 = 3'd4, OE_GPIN1 = 3'd5, OE_LOCAL = 3'd6, OE_NONE = 3'd7
  } oe_sel_e;
endpackage

// File: rtl/bsc_oe_mux.sv
module bsc_oe_mux
  import bsc_pkg::*;
(
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_GPT-1:0]  gpt_oe_i,
  input  logic [NUM_GPIN-1:0] goe_pin_i,
  input  logic                pt_oe_i,
  output logic                oe_o
);
  always_comb begin
    unique case (oe_sel_e'(sel_i))
      OE_GPT0:  oe_o = gpt_oe_i[0];
      OE_GPT1:  oe_o = gpt_oe_i[1];
      OE_GPT2:  oe_o = gpt_oe_i[2];
      OE_GPT3:  oe_o = gpt_oe_i[3];
      OE_GPIN0: oe_o = goe_pin_i[0];
      OE_GPIN1: oe_o = goe_pin_i[1];
      OE_LOCAL: oe_o = pt_oe_i;
      default:  oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsc_bidir_cell.sv
module bsc_bidir_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clock_dr_i,
  input  logic shift_dr_i,
  input  logic update_dr_i,
  input  logic si_i,
  input  logic cap_data_i,
  input  logic cap_oe_i,
  input  logic cap_in_i,
  output logic so_o,
  output logic upd_data_o,
  output logic upd_oe_o
);
  // stage 0 data, 1 enable, 2 pad input
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (clock_dr_i) begin
      if (shift_dr_i) sh_q <= {sh_q[1:0], si_i};
      else            sh_q <= {cap_in_i, cap_oe_i, cap_data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_data_o <= 1'b0;
      upd_oe_o   <= 1'b0;
    end else if (update_dr_i) begin
      upd_data_o <= sh_q[0];
      upd_oe_o   <= sh_q[1];
    end
  end

  assign so_o = sh_q[2];

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clock_dr_i && shift_dr_i |=> sh_q[0] == $past(si_i) && sh_q[2:1] == $past(sh_q[1:0]));
  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clock_dr_i && !shift_dr_i |=> sh_q == $past({cap_in_i, cap_oe_i, cap_data_i}));
  p_update_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_dr_i |=> {upd_oe_o, upd_data_o} == $past(sh_q[1:0]));
  p_noupd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_dr_i |=> $stable({upd_oe_o, upd_data_o}));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clock_dr_i |=> $stable(sh_q));
endmodule

// File: rtl/bsc_in_cell.sv
module bsc_in_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clock_dr_i,
  input  logic shift_dr_i,
  input  logic si_i,
  input  logic cap_i,
  output logic so_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        so_o <= 1'b0;
    else if (clock_dr_i) so_o <= shift_dr_i ? si_i : cap_i;
  end

  p_in_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clock_dr_i |=> $stable(so_o));
endmodule

// File: rtl/bsc_pin_drive.sv
module bsc_pin_drive (
  input  logic func_data_i,
  input  logic func_oe_i,
  input  logic upd_data_i,
  input  logic upd_oe_i,
  input  logic extest_i,
  input  logic highz_i,
  input  logic test_oe_ni,
  output logic pad_out_o,
  output logic pad_oe_o
);
  logic oe_pre;
  assign pad_out_o = extest_i ? upd_data_i : func_data_i;
  assign oe_pre    = extest_i ? upd_oe_i   : func_oe_i;
  // both overrides win over any enable source
  assign pad_oe_o  = oe_pre & test_oe_ni & ~highz_i;
endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int unsigned NUM_BIDIR = 4,
  parameter int unsigned NUM_INPUT = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clock_dr_i,
  input  logic                       shift_dr_i,
  input  logic                       update_dr_i,
  input  logic                       extest_i,
  input  logic                       highz_i,
  input  logic                       test_oe_ni,
  input  logic                       scan_in_i,
  output logic                       scan_out_o,
  input  logic [NUM_BIDIR-1:0]       func_out_i,
  input  logic [SEL_W*NUM_BIDIR-1:0] oe_sel_i,
  input  logic [NUM_GPT-1:0]         gpt_oe_i,
  input  logic [NUM_GPIN-1:0]        goe_pin_i,
  input  logic [NUM_BIDIR-1:0]       pt_oe_i,
  input  logic [NUM_BIDIR-1:0]       pad_in_i,
  input  logic [NUM_INPUT-1:0]       in_pin_i,
  output logic [NUM_BIDIR-1:0]       pad_out_o,
  output logic [NUM_BIDIR-1:0]       pad_oe_o
);
  localparam int unsigned NUM_LINKS = NUM_BIDIR + NUM_INPUT;

  logic [NUM_LINKS:0]    link;
  logic [NUM_BIDIR-1:0]  func_oe, upd_data, upd_oe;

  assign link[0] = scan_in_i;

  for (genvar p = 0; p < NUM_BIDIR; p++) begin : g_bidir
    bsc_oe_mux u_oe_mux (
      .sel_i     (oe_sel_i[SEL_W*p +: SEL_W]),
      .gpt_oe_i  (gpt_oe_i),
      .goe_pin_i (goe_pin_i),
      .pt_oe_i   (pt_oe_i[p]),
      .oe_o      (func_oe[p])
    );
    bsc_bidir_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clock_dr_i  (clock_dr_i),
      .shift_dr_i  (shift_dr_i),
      .update_dr_i (update_dr_i),
      .si_i        (link[p]),
      .cap_data_i  (func_out_i[p]),
      .cap_oe_i    (func_oe[p]),
      .cap_in_i    (pad_in_i[p]),
      .so_o        (link[p+1]),
      .upd_data_o  (upd_data[p]),
      .upd_oe_o    (upd_oe[p])
    );
    bsc_pin_drive u_drive (
      .func_data_i (func_out_i[p]),
      .func_oe_i   (func_oe[p]),
      .upd_data_i  (upd_data[p]),
      .upd_oe_i    (upd_oe[p]),
      .extest_i    (extest_i),
      .highz_i     (highz_i),
      .test_oe_ni  (test_oe_ni),
      .pad_out_o   (pad_out_o[p]),
      .pad_oe_o    (pad_oe_o[p])
    );
  end

  for (genvar i = 0; i < NUM_INPUT; i++) begin : g_input
    bsc_in_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clock_dr_i (clock_dr_i),
      .shift_dr_i (shift_dr_i),
      .si_i       (link[NUM_BIDIR+i]),
      .cap_i      (in_pin_i[i]),
      .so_o       (link[NUM_BIDIR+i+1])
    );
  end

  // serial output retimed to the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scan_out_o <= 1'b0;
    else         scan_out_o <= link[NUM_LINKS];
  end

  p_tdo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_out_o == link[NUM_LINKS]);
  p_toe_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_oe_ni |-> pad_oe_o == '0);
  p_highz_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    highz_i |-> pad_oe_o == '0);
  p_extest_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extest_i |-> pad_out_o == upd_data);
endmodule

// File: tb/bsc_chain_bench.sv
module bsc_chain_bench;
  localparam int NB  = 4;
  localparam int NI  = 2;
  localparam int LEN = 3*NB + NI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clock_dr = 0, shift_dr = 0, update_dr = 0, extest = 0, highz = 0, toe_n = 1, sin = 0;
  logic sout;
  logic [NB-1:0]   func_out = '0, pt_oe = '0, pad_in = '0, pad_out, pad_oe;
  logic [3*NB-1:0] oe_sel = '0;
  logic [3:0]      gpt = '0;
  logic [1:0]      gpin = '0;
  logic [NI-1:0]   in_pin = '0;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bsc_chain #(.NUM_BIDIR(NB), .NUM_INPUT(NI)) u_bsc_chain (
    .clk_i(clk), .rst_ni(rst_n), .clock_dr_i(clock_dr), .shift_dr_i(shift_dr),
    .update_dr_i(update_dr), .extest_i(extest), .highz_i(highz), .test_oe_ni(toe_n),
    .scan_in_i(sin), .scan_out_o(sout), .func_out_i(func_out), .oe_sel_i(oe_sel),
    .gpt_oe_i(gpt), .goe_pin_i(gpin), .pt_oe_i(pt_oe), .pad_in_i(pad_in),
    .in_pin_i(in_pin), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  function automatic logic exp_oe(input logic [2:0] s, input logic [3:0] g,
                                  input logic [1:0] gp, input logic pt);
    if (s < 3'd4)       return g[s[1:0]];
    else if (s < 3'd6)  return gp[s[0]];
    else if (s == 3'd6) return pt;
    else                return 1'b0;
  endfunction

  // shifts din in (cell k ends with din[k]), returns old contents and scan_out just after first shift edge
  task automatic shift_io(input logic [LEN-1:0] din, output logic [LEN-1:0] got, output logic first_mid);
    shift_dr = 1; clock_dr = 1;
    for (int i = 0; i < LEN; i++) begin
      sin = din[LEN-1-i];
      #10;
      got[LEN-1-i] = sout;
      tick();
      if (i == 0) first_mid = sout;
    end
    clock_dr = 0; shift_dr = 0;
  endtask

  task automatic t_reset();
    extest = 1;
    #1;
    check("R1 pad_oe after reset", pad_oe, 0);
    check("R1 pad_out after reset", pad_out, 0);
    check("R1 scan_out after reset", sout, 0);
    extest = 0;
  endtask

  task automatic t_capture_order();
    logic [LEN-1:0] exp, got;
    logic mid;
    func_out = 4'b1010; pad_in = 4'b0110; pt_oe = 4'b1001; gpt = 4'b0101; gpin = 2'b10;
    oe_sel = {3'd7, 3'd5, 3'd1, 3'd6}; in_pin = 2'b01;
    for (int p = 0; p < NB; p++) begin
      exp[3*p]   = func_out[p];
      exp[3*p+1] = exp_oe(oe_sel[3*p +: 3], gpt, gpin, pt_oe[p]);
      exp[3*p+2] = pad_in[p];
    end
    for (int i = 0; i < NI; i++) exp[3*NB+i] = in_pin[i];
    clock_dr = 1; shift_dr = 0;
    tick();
    clock_dr = 0;
    // R10: strobe activity without clock_dr must not disturb the captured chain
    for (int i = 0; i < 4; i++) begin
      shift_dr = i[0]; sin = ~i[0];
      tick();
    end
    shift_dr = 0;
    shift_io('0, got, mid);
    check("R4 R2 captured chain order", got, exp);
    check("R10 chain held with clock_dr low", got[LEN-1:LEN-2], exp[LEN-1:LEN-2]);
    check("R3 scan_out stable until falling edge", mid, exp[LEN-1]);
  endtask

  task automatic t_load_update();
    logic [LEN-1:0] pat, got;
    logic mid;
    logic [NB-1:0] ed, eo;
    pat = 14'b10_110_011_101_110;
    extest = 1;
    shift_io(pat, got, mid);
    check("R5 pads untouched by shift", {pad_out, pad_oe}, 0);
    update_dr = 1;
    tick();
    update_dr = 0;
    #1;
    for (int p = 0; p < NB; p++) begin
      ed[p] = pat[3*p]; eo[p] = pat[3*p+1];
    end
    check("R5 R6 pad_out from update", pad_out, ed);
    check("R5 R6 pad_oe from update", pad_oe, eo);
    shift_io('1, got, mid);
    check("R2 loaded pattern read back", got, pat);
    check("R5 shift w/o update keeps pads", {pad_out, pad_oe}, {ed, eo});
    extest = 0; oe_sel = {NB{3'd6}}; pt_oe = 4'b0011; func_out = 4'b0101;
    #1;
    check("R6 functional data", pad_out, 4'b0101);
    check("R6 functional enable", pad_oe, 4'b0011);
  endtask

  task automatic t_oe_select();
    for (int s = 0; s < 8; s++) begin
      oe_sel = {9'd0, 3'(s)};
      gpt = 4'b0110; gpin = 2'b01; pt_oe = 4'b0001;
      #1;
      check($sformatf("R7 sel=%0d set A", s), pad_oe[0], exp_oe(3'(s), gpt, gpin, pt_oe[0]));
      gpt = 4'b1001; gpin = 2'b10; pt_oe = 4'b0000;
      #1;
      check($sformatf("R7 sel=%0d set B", s), pad_oe[0], exp_oe(3'(s), gpt, gpin, pt_oe[0]));
    end
  endtask

  task automatic t_tristate();
    logic [LEN-1:0] got;
    logic mid;
    extest = 0; oe_sel = {NB{3'd6}}; pt_oe = '1; highz = 0; toe_n = 1;
    #1; check("R9 R8 baseline enables on", pad_oe, 4'hF);
    toe_n = 0; #1; check("R8 test_oe low functional", pad_oe, 0);
    toe_n = 1; highz = 1; #1; check("R9 highz functional", pad_oe, 0);
    highz = 0;
    extest = 1;
    shift_io({LEN{1'b1}}, got, mid);
    update_dr = 1; tick(); update_dr = 0;
    #1; check("R6 extest all enabled", pad_oe, 4'hF);
    toe_n = 0; #1; check("R8 test_oe low extest", pad_oe, 0);
    toe_n = 1; highz = 1; #1; check("R9 highz extest", pad_oe, 0);
    highz = 0; extest = 0;
  endtask

  initial begin
    #200000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1;
    tick();
    t_reset();
    t_capture_order();
    t_load_update();
    t_oe_select();
    t_tristate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule